// File: doc/BRIEF.md
# Sticky Fault Status and Alert Combiner

This block gathers level-type fault indications from five temperature channels and from one fan driver into sticky status registers. A bit sets while its fault input is high and stays set after the input falls. It is cleared only when software reads the register that holds it and the fault has already gone away. A two-bit summary register shows which group has latched faults. An active-low alert pin is driven low while any latched bit is set that is not masked.

Software reaches the block through a plain register port. A single-cycle `rd_en` strobe with an address returns the register contents on `rd_data` one cycle later, with `rd_valid` high for that cycle. The clearing side effect of a read applies at the same clock edge that captures the data, so the returned value shows the bits as they stood before the clear. A `wr_en` strobe writes the two mask registers. There is no back-pressure: the port accepts every strobe, and a read can be issued in every cycle.

Register map, with 3-bit addresses: 0 summary, 1 temperature status, 2 fan status, 3 temperature alert enable, 4 fan alert mask. Addresses 5 to 7 are unmapped.

Top module: `therm_alert_hub`

## Requirements
- R1: After reset, every status register, the temperature enable register and the fan mask register read 00h, `alert_n` is 1 and `rd_valid` is 0.
- R2: A high fault input sets its status bit at the next clock edge, and the bit stays set after the input falls. Temperature status uses bit 0 for internal, bits 1 to 3 for external channels 1 to 3 and bit 4 for PWM. Fan status uses bit 7 for watchdog expired, bit 5 for drive fail, bit 1 for spin-up fail and bit 0 for stall.
- R3: A read strobe returns the addressed register's value from before the edge on `rd_data`, with `rd_valid` high, in the following cycle. A read of a detail status register (address 1 or 2) clears every bit whose fault input is low at that edge.
- R4: A bit whose fault input is high at the edge of a detail read stays set. This includes a fault that rises again in the same cycle as the read.
- R5: In the summary register (address 0), bit 0 is set when any temperature status bit is set and bit 1 is set when any fan status bit is set. Masks do not affect these bits. Reading the summary register clears nothing.
- R6: The temperature enable register (address 3, bits 0 to 4, same positions as the status bits) is read/write. A latched bit whose enable is 0 does not pull `alert_n` low.
- R7: The fan mask register (address 4) holds bits 5, 1 and 0. A 1 in one of these bits keeps drive fail, spin-up fail or stall, respectively, from pulling `alert_n` low, and the masked bit still latches. Watchdog expired cannot be masked.
- R8: `alert_n` goes low one cycle after an unmasked status bit becomes set. It returns high one cycle after the last such bit clears.
- R9: Writes to addresses 0, 1 and 2 have no effect. Register bits with no function read 0.
- R10: A read of an unmapped address (5 to 7) returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_fault | input | 5 | Temperature channel fault levels |
| wdog_expired | input | 1 | Watchdog expired level |
| drive_fail | input | 1 | Fan cannot reach target at full drive |
| spin_fail | input | 1 | Spin-up found no valid tachometer reading |
| fan_stall | input | 1 | Stalled fan detected |
| rd_en | input | 1 | One-cycle read strobe |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a fault that is low before a clearing read, rises again in exactly the cycle of the read strobe, and falls afterwards. If the block cleared the bit instead of keeping it, the loss would only show on a later read. The bench drives the fault and the read strobe at the same falling edge, removes the fault one cycle later, and then reads twice. The first read must still return the bit, and the second must return zero. Alert timing is checked cycle by cycle around both the set edge and the clear edge.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int N_TEMP  = 5;
  localparam int N_FAN   = 4;   // {watchdog, drive fail, spin fail, stall}
  localparam int N_MASK  = 3;   // {drive fail, spin fail, stall}

  localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd0;
  localparam logic [ADDR_W-1:0] A_TEMP_ST = 3'd1;
  localparam logic [ADDR_W-1:0] A_FAN_ST  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TEMP_EN = 3'd3;
  localparam logic [ADDR_W-1:0] A_FAN_MSK = 3'd4;

  localparam int BIT_WDOG  = 7;
  localparam int BIT_DRIVE = 5;
  localparam int BIT_SPIN  = 1;
  localparam int BIT_STALL = 0;
endpackage

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fault,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= fault[i] | (q[i] & ~clr);
    end
  end

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != '0) |=> ((q & $past(fault)) == $past(fault)));
  assert_clear_gone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((q & ~$past(fault)) == '0));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/alert_merge.sv
module alert_merge #(
  parameter int NT = 5,
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] temp_q,
  input  logic [NT-1:0] temp_en,
  input  logic          wdog_q,
  input  logic [NM-1:0] fan_q,
  input  logic [NM-1:0] fan_mask,
  output logic          alert_n
);
  logic any_active;
  assign any_active = (|(temp_q & temp_en)) | wdog_q | (|(fan_q & ~fan_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= ~any_active;
  end

  assert_alert_temp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(temp_q & temp_en)) |=> !alert_n);
  assert_wdog_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_q |=> !alert_n);
  assert_alert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((temp_q & temp_en) == '0 && !wdog_q && (fan_q & ~fan_mask) == '0) |=> alert_n);
endmodule

// File: rtl/therm_alert_hub.sv
module therm_alert_hub
  import therm_alert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TEMP-1:0] temp_fault,
  input  logic              wdog_expired,
  input  logic              drive_fail,
  input  logic              spin_fail,
  input  logic              fan_stall,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              alert_n
);
  localparam int PAD_T = DATA_W - N_TEMP;

  logic [N_TEMP-1:0] temp_q, temp_en_q;
  logic [N_FAN-1:0]  fan_q;
  logic [N_MASK-1:0] mask_q;
  logic              clr_temp, clr_fan;
  logic [DATA_W-1:0] fan_view, mask_view, rd_mux;
  logic              unused_wr_bits;

  assign clr_temp = rd_en && (addr == A_TEMP_ST);
  assign clr_fan  = rd_en && (addr == A_FAN_ST);
  assign unused_wr_bits = ^{wr_data[7:6], wr_data[4:2]};

  sticky_bits #(.W(N_TEMP)) u_temp_st (
    .clk(clk), .rst_n(rst_n), .fault(temp_fault), .clr(clr_temp), .q(temp_q));

  sticky_bits #(.W(N_FAN)) u_fan_st (
    .clk(clk), .rst_n(rst_n),
    .fault({wdog_expired, drive_fail, spin_fail, fan_stall}),
    .clr(clr_fan), .q(fan_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_en_q <= '0;
      mask_q    <= '0;
    end else if (wr_en) begin
      if (addr == A_TEMP_EN) temp_en_q <= wr_data[N_TEMP-1:0];
      if (addr == A_FAN_MSK) mask_q    <= {wr_data[BIT_DRIVE], wr_data[BIT_SPIN], wr_data[BIT_STALL]};
    end
  end

  always_comb begin
    fan_view            = '0;
    fan_view[BIT_WDOG]  = fan_q[3];
    fan_view[BIT_DRIVE] = fan_q[2];
    fan_view[BIT_SPIN]  = fan_q[1];
    fan_view[BIT_STALL] = fan_q[0];
    mask_view            = '0;
    mask_view[BIT_DRIVE] = mask_q[2];
    mask_view[BIT_SPIN]  = mask_q[1];
    mask_view[BIT_STALL] = mask_q[0];
    case (addr)
      A_SUMMARY: rd_mux = {{(DATA_W-2){1'b0}}, |fan_q, |temp_q};
      A_TEMP_ST: rd_mux = {{PAD_T{1'b0}}, temp_q};
      A_FAN_ST:  rd_mux = fan_view;
      A_TEMP_EN: rd_mux = {{PAD_T{1'b0}}, temp_en_q};
      A_FAN_MSK: rd_mux = mask_view;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  alert_merge #(.NT(N_TEMP), .NM(N_MASK)) u_alert (
    .clk(clk), .rst_n(rst_n),
    .temp_q(temp_q), .temp_en(temp_en_q),
    .wdog_q(fan_q[3]), .fan_q(fan_q[2:0]), .fan_mask(mask_q),
    .alert_n(alert_n));

  assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_summary_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SUMMARY) |=> (temp_q == $past(temp_q) || $past(temp_fault) != '0));
  assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == A_TEMP_ST && temp_fault == '0) |=> temp_q == $past(temp_q));
endmodule

// File: tb/therm_alert_hub_bench.sv
module therm_alert_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] temp_fault = '0;
  logic       wdog_expired = 1'b0, drive_fail = 1'b0, spin_fail = 1'b0, fan_stall = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, alert_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  therm_alert_hub u_therm_alert_hub (
    .clk(clk), .rst_n(rst_n), .temp_fault(temp_fault),
    .wdog_expired(wdog_expired), .drive_fail(drive_fail),
    .spin_fail(spin_fail), .fan_stall(fan_stall),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .alert_n(alert_n));

  // {temp_fault[4:0], fan{wdog,drive,spin,stall}, exp_temp[7:0], exp_fan[7:0]}
  localparam logic [24:0] VEC [0:7] = '{
    {5'b00001, 4'b0000, 8'h01, 8'h00},
    {5'b10000, 4'b0000, 8'h10, 8'h00},
    {5'b01010, 4'b1000, 8'h0A, 8'h80},
    {5'b00000, 4'b0100, 8'h00, 8'h20},
    {5'b00000, 4'b0010, 8'h00, 8'h02},
    {5'b00000, 4'b0001, 8'h00, 8'h01},
    {5'b11111, 4'b1111, 8'h1F, 8'hA3},
    {5'b00100, 4'b0101, 8'h04, 8'h21}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_fan(input logic [3:0] f);
    {wdog_expired, drive_fail, spin_fail, fan_stall} = f;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 alert_n", {7'b0, alert_n}, 8'h01);
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    rd(3'd1); check("R1 temp status", rd_data, 8'h00);
    rd(3'd2); check("R1 fan status", rd_data, 8'h00);
    rd(3'd3); check("R1 temp enable", rd_data, 8'h00);
    rd(3'd4); check("R1 fan mask", rd_data, 8'h00);

    // R2/R3 vector walk: pulse faults, then read and clear
    for (int i = 0; i < 8; i++) begin
      temp_fault = VEC[i][24:20];
      set_fan(VEC[i][19:16]);
      step();
      temp_fault = '0; set_fan(4'b0);
      step();
      rd(3'd1); check("R2 temp latch", rd_data, VEC[i][15:8]);
      check("R3 rd_valid", {7'b0, rd_valid}, 8'h01);
      rd(3'd2); check("R2 fan latch", rd_data, VEC[i][7:0]);
      rd(3'd1); check("R3 temp cleared", rd_data, 8'h00);
      rd(3'd2); check("R3 fan cleared", rd_data, 8'h00);
    end
    step();
    check("R3 rd_valid low", {7'b0, rd_valid}, 8'h00);

    // R4 persistent fault survives reads
    temp_fault = 5'b00100;
    step();
    rd(3'd1); check("R4 persistent read1", rd_data, 8'h04);
    rd(3'd1); check("R4 persistent read2", rd_data, 8'h04);
    temp_fault = '0;
    rd(3'd1); check("R4 after removal", rd_data, 8'h04);
    rd(3'd1); check("R4 now cleared", rd_data, 8'h00);

    // R4 fault reasserting in the same cycle as the clearing read
    temp_fault = 5'b00100; step(); temp_fault = '0; step();
    temp_fault = 5'b00100; rd_en = 1'b1; addr = 3'd1;
    step();
    rd_en = 1'b0; temp_fault = '0;
    check("R4 same-cycle read data", rd_data, 8'h04);
    rd(3'd1); check("R4 same-cycle kept", rd_data, 8'h04);
    rd(3'd1); check("R4 same-cycle later clear", rd_data, 8'h00);

    // R5 summary
    temp_fault = 5'b00001; fan_stall = 1'b1; step();
    temp_fault = '0; fan_stall = 1'b0;
    rd(3'd0); check("R5 summary both", rd_data, 8'h03);
    rd(3'd0); check("R5 summary read no clear", rd_data, 8'h03);
    rd(3'd1); check("R5 temp still set", rd_data, 8'h01);
    rd(3'd0); check("R5 summary fan only", rd_data, 8'h02);
    rd(3'd2); check("R5 fan still set", rd_data, 8'h01);
    rd(3'd0); check("R5 summary empty", rd_data, 8'h00);

    // R6 disabled channel does not alert
    temp_fault = 5'b00001; step(); temp_fault = '0; step();
    check("R6 disabled no alert", {7'b0, alert_n}, 8'h01);
    wr(3'd3, 8'h01); step();
    check("R6 enabled alert", {7'b0, alert_n}, 8'h00);
    rd(3'd1);
    check("R8 alert still low at clear edge", {7'b0, alert_n}, 8'h00);
    step();
    check("R8 alert released", {7'b0, alert_n}, 8'h01);

    // R8 set timing
    temp_fault = 5'b00001; step();
    check("R8 alert not yet", {7'b0, alert_n}, 8'h01);
    temp_fault = '0; step();
    check("R8 alert low", {7'b0, alert_n}, 8'h00);
    rd(3'd1); step();
    check("R8 alert high after clear", {7'b0, alert_n}, 8'h01);

    // R7 fan mask
    wr(3'd4, 8'h23);
    rd(3'd4); check("R7 mask readback", rd_data, 8'h23);
    set_fan(4'b0111); step(); set_fan(4'b0000); step(); step();
    check("R7 masked no alert", {7'b0, alert_n}, 8'h01);
    rd(3'd2); check("R7 masked still latched", rd_data, 8'h23);
    wdog_expired = 1'b1; step(); wdog_expired = 1'b0; step();
    check("R7 watchdog unmaskable", {7'b0, alert_n}, 8'h00);
    rd(3'd2); check("R7 watchdog latched", rd_data, 8'h80);
    step();
    check("R7 alert high after clear", {7'b0, alert_n}, 8'h01);
    wr(3'd4, 8'h00);
    fan_stall = 1'b1; step(); fan_stall = 1'b0; step();
    check("R7 unmasked stall alerts", {7'b0, alert_n}, 8'h00);
    rd(3'd2); step();

    // R9 writes to read-only registers, unused bits
    temp_fault = 5'b00010; step(); temp_fault = '0;
    wr(3'd1, 8'h00); wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd1); check("R9 status write ignored", rd_data, 8'h02);
    rd(3'd2); check("R9 fan write ignored", rd_data, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd3); check("R9 enable unused bits", rd_data, 8'h1F);
    wr(3'd4, 8'hFF);
    rd(3'd4); check("R9 mask unused bits", rd_data, 8'h23);

    // R10 unmapped addresses
    rd(3'd5); check("R10 addr5", rd_data, 8'h00);
    rd(3'd7); check("R10 addr7", rd_data, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule